// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Port

This block gives software a port of `LINES` general-purpose pins through a small synchronous register bus. Each cycle the bus may carry one write (address, write enable, write data) or one read (address, read enable), and read data comes back on the following clock. The block drives an output level and an output enable for every line. It samples the pad levels through a two-flop synchronizer, so the pad state can be read back.

Build-time parameters decide which registers exist and so which update rules apply. These registers can be chosen:
- a level register;
- a write-one set register, which loads the whole output value when no clear register is built;
- a write-one clear register;
- a direction register of either polarity, or no direction register at all.

Further parameters make the port input-only and choose whether the bus byte order differs from the native order. When it differs, byte lanes are swapped on both writes and reads.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After reset the output value is zero, every line with a direction register is an input, and the read data port is zero.
- R2: A read of word address 0 (level register) returns the synchronized pad levels, bit i for line i, one clock after the read request, with each pad passing through two flops before it is read.
- R3: When no set register is built, a write to word address 0 loads the output value of all lines.
- R4: When both set and clear registers exist, writing 1 to a bit of word address 1 drives that line high, and a 0 bit leaves it unchanged.
- R5: Writing 1 to a bit of word address 2 (clear register) drives that line low, and a 0 bit leaves it unchanged.
- R6: When a set register exists and the clear register does not, a write to word address 1 loads the full output value, so 0 bits drive their lines low.
- R7: With an output-polarity direction register at word address 3, a 1 bit enables the line as an output and a 0 bit makes it an input. A read of address 3 returns the stored value.
- R8: With an input-polarity direction register at word address 3, a 1 bit makes the line an input and a 0 bit enables it as an output. This register resets to all ones.
- R9: With no direction register and outputs allowed, every line's output enable is 1.
- R10: In the input-only variant every output enable stays 0, and writes to addresses 0, 1 and 2 leave the output value at zero.
- R11: When the bus byte order differs from the native order, the byte lanes of write data and read data are reversed (byte 0 swaps with the top byte).
- R12: Reads of an absent register, of the write-only set and clear addresses, and of unmapped addresses 4 to 7 return zero. Writes to absent registers or unmapped addresses change neither the output value nor the output enables.
- R13: In a cycle that follows a clock edge with no read request, the read data port is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Word address of the access |
| bus_we_i | input | 1 | Write request |
| bus_wdata_i | input | LINES | Write data in bus byte order |
| bus_re_i | input | 1 | Read request |
| bus_rdata_o | output | LINES | Read data in bus byte order, valid the clock after the request |
| pad_i | input | LINES | Asynchronous pad levels |
| pad_out_o | output | LINES | Output level of each line |
| pad_oe_o | output | LINES | Output enable of each line |

## Verification
Register writes take effect on the clock edge that samples the request. The bench therefore compares output level and enable at the falling edge just after that rising edge. Read data is registered once, so it is compared at the falling edge after the edge that took the request, and checked again one edge later to confirm it returned to zero. A pad change needs two rising edges through the synchronizer before a read can capture it. The bench holds each pad pattern for at least three rising edges before it issues the read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // word addresses of the register slots
    localparam int unsigned SLOT_LEVEL = 0;
    localparam int unsigned SLOT_SET   = 1;
    localparam int unsigned SLOT_CLR   = 2;
    localparam int unsigned SLOT_DIR   = 3;

    // direction register flavours
    localparam int unsigned DIR_NONE   = 0;
    localparam int unsigned DIR_OUTPOL = 1;  // 1 = output
    localparam int unsigned DIR_INPOL  = 2;  // 1 = input
endpackage

// File: rtl/gpio_byte_swap.sv
module gpio_byte_swap #(
    parameter int unsigned LINES = 16,
    parameter bit          SWAP  = 1'b0
) (
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    localparam int unsigned NBYTES = LINES / 8;

    generate
        if (SWAP && (LINES % 8 == 0) && (NBYTES > 1)) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_lane
                assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    logic [LINES-1:0] stage1_q;
    logic [LINES-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned LINES      = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter bit          HAS_SET    = 1'b1,
    parameter bit          HAS_CLR    = 1'b1,
    parameter int unsigned DIR_MODE   = DIR_OUTPOL,
    parameter bit          INPUT_ONLY = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [LINES-1:0]  wdata_i,
    input  logic              re_i,
    input  logic [LINES-1:0]  pad_sync_i,
    output logic [LINES-1:0]  rdata_o,
    output logic [LINES-1:0]  out_o,
    output logic [LINES-1:0]  oe_o
);
    localparam bit               HAS_DIR   = (DIR_MODE != DIR_NONE);
    localparam logic [LINES-1:0] DIR_RESET = (DIR_MODE == DIR_INPOL) ? '1 : '0;

    typedef struct packed {
        logic [LINES-1:0] out;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        if (we_i) begin
            unique case (addr_i)
                ADDR_W'(SLOT_LEVEL): begin
                    if (!HAS_SET && !INPUT_ONLY) st_d.out = wdata_i;
                end
                ADDR_W'(SLOT_SET): begin
                    if (HAS_SET && !INPUT_ONLY) begin
                        st_d.out = HAS_CLR ? (st_q.out | wdata_i) : wdata_i;
                    end
                end
                ADDR_W'(SLOT_CLR): begin
                    if (HAS_CLR && !INPUT_ONLY) st_d.out = st_q.out & ~wdata_i;
                end
                ADDR_W'(SLOT_DIR): begin
                    if (HAS_DIR) st_d.dir = wdata_i;
                end
                default: ;
            endcase
        end

        if (re_i) begin
            unique case (addr_i)
                ADDR_W'(SLOT_LEVEL): st_d.rdata = pad_sync_i;
                ADDR_W'(SLOT_DIR):   st_d.rdata = HAS_DIR ? st_q.dir : '0;
                default:             st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.out   <= '0;
            st_q.dir   <= DIR_RESET;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (INPUT_ONLY) begin : g_oe_off
            assign oe_o = '0;
        end else if (DIR_MODE == DIR_OUTPOL) begin : g_oe_out
            assign oe_o = st_q.dir;
        end else if (DIR_MODE == DIR_INPOL) begin : g_oe_in
            assign oe_o = ~st_q.dir;
        end else begin : g_oe_all
            assign oe_o = '1;
        end
    endgenerate

    assign out_o   = st_q.out;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned LINES      = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter bit          HAS_SET    = 1'b1,
    parameter bit          HAS_CLR    = 1'b1,
    parameter int unsigned DIR_MODE   = DIR_OUTPOL,
    parameter bit          INPUT_ONLY = 1'b0,
    parameter bit          BUS_BE     = 1'b0,
    parameter bit          NATIVE_BE  = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    input  logic              bus_re_i,
    output logic [LINES-1:0]  bus_rdata_o,
    input  logic [LINES-1:0]  pad_i,
    output logic [LINES-1:0]  pad_out_o,
    output logic [LINES-1:0]  pad_oe_o
);
    localparam bit SWAP = (BUS_BE != NATIVE_BE);

    logic [LINES-1:0] wdata_nat;
    logic [LINES-1:0] rdata_nat;
    logic [LINES-1:0] pad_sync;

    gpio_byte_swap #(.LINES(LINES), .SWAP(SWAP)) u_wr_swap (
        .din  (bus_wdata_i),
        .dout (wdata_nat)
    );

    gpio_sync2 #(.LINES(LINES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pad_i),
        .sync_o  (pad_sync)
    );

    gpio_regs #(
        .LINES      (LINES),
        .ADDR_W     (ADDR_W),
        .HAS_SET    (HAS_SET),
        .HAS_CLR    (HAS_CLR),
        .DIR_MODE   (DIR_MODE),
        .INPUT_ONLY (INPUT_ONLY)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .wdata_i    (wdata_nat),
        .re_i       (bus_re_i),
        .pad_sync_i (pad_sync),
        .rdata_o    (rdata_nat),
        .out_o      (pad_out_o),
        .oe_o       (pad_oe_o)
    );

    gpio_byte_swap #(.LINES(LINES), .SWAP(SWAP)) u_rd_swap (
        .din  (rdata_nat),
        .dout (bus_rdata_o)
    );
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int unsigned LINES      = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned DIR_MODE   = 1,
    parameter bit          INPUT_ONLY = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic              bus_re_i,
    input logic [LINES-1:0]  bus_rdata_o,
    input logic [LINES-1:0]  pad_out_o,
    input logic [LINES-1:0]  pad_oe_o
);
    localparam int unsigned FIRST_HOLE = 4;
    localparam bool_t_dummy = 0;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_re_i |=> (bus_rdata_o == '0)); // R13

    AST_INPUT_ONLY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        INPUT_ONLY |-> (pad_oe_o == '0 && pad_out_o == '0)); // R10

    AST_NO_DIR_ALL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (DIR_MODE == 0 && !INPUT_ONLY) |-> (&pad_oe_o)); // R9

    AST_IDLE_HOLDS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_we_i |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R4

    AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i >= ADDR_W'(FIRST_HOLE)) |=>
            ($stable(pad_out_o) && $stable(pad_oe_o))); // R12

    AST_HOLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i >= ADDR_W'(FIRST_HOLE)) |=> (bus_rdata_o == '0)); // R12
endmodule

bind mmio_gpio_ctrl gpio_ctrl_chk #(
    .LINES      (LINES),
    .ADDR_W     (ADDR_W),
    .DIR_MODE   (DIR_MODE),
    .INPUT_ONLY (INPUT_ONLY)
) u_gpio_ctrl_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_rdata_o (bus_rdata_o),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o)
);

// File: tb/test_mmio_gpio_ctrl.sv
`timescale 1ns/1ps
module test_mmio_gpio_ctrl;
    localparam int unsigned L = 16;
    localparam int unsigned AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [L-1:0]  wdata = '0;
    logic [L-1:0]  pads = '0;

    logic [L-1:0] rd_a, rd_b, rd_c, rd_d;
    logic [L-1:0] out_a, out_b, out_c, out_d;
    logic [L-1:0] oe_a, oe_b, oe_c, oe_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [L-1:0] e_out_a, e_out_b, e_out_c;
    logic [L-1:0] e_dir_a, e_dir_c, e_dir_d;

    always #2 clk = ~clk;  // 250 MHz

    // A: set+clear, output-polarity direction, swapped bus order
    mmio_gpio_ctrl #(.LINES(L), .ADDR_W(AW), .HAS_SET(1), .HAS_CLR(1), .DIR_MODE(1),
                     .INPUT_ONLY(0), .BUS_BE(1), .NATIVE_BE(0)) i_mmio_gpio_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rd_a), .pad_i(pads), .pad_out_o(out_a), .pad_oe_o(oe_a));

    // B: level register only, no direction register
    mmio_gpio_ctrl #(.LINES(L), .ADDR_W(AW), .HAS_SET(0), .HAS_CLR(0), .DIR_MODE(0),
                     .INPUT_ONLY(0), .BUS_BE(0), .NATIVE_BE(0)) i_dut_b (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rd_b), .pad_i(pads), .pad_out_o(out_b), .pad_oe_o(oe_b));

    // C: set without clear, input-polarity direction
    mmio_gpio_ctrl #(.LINES(L), .ADDR_W(AW), .HAS_SET(1), .HAS_CLR(0), .DIR_MODE(2),
                     .INPUT_ONLY(0), .BUS_BE(1), .NATIVE_BE(1)) i_dut_c (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rd_c), .pad_i(pads), .pad_out_o(out_c), .pad_oe_o(oe_c));

    // D: input-only
    mmio_gpio_ctrl #(.LINES(L), .ADDR_W(AW), .HAS_SET(1), .HAS_CLR(1), .DIR_MODE(1),
                     .INPUT_ONLY(1), .BUS_BE(0), .NATIVE_BE(0)) i_dut_d (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rd_d), .pad_i(pads), .pad_out_o(out_d), .pad_oe_o(oe_d));

    function automatic logic [L-1:0] swp(input logic [L-1:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_lines();
        chk("R4 R5 R11 A out", out_a, e_out_a);
        chk("R7 A oe", oe_a, e_dir_a);
        chk("R3 R12 B out", out_b, e_out_b);
        chk("R9 B oe", oe_b, '1);
        chk("R6 C out", out_c, e_out_c);
        chk("R8 C oe", oe_c, ~e_dir_c);
        chk("R10 D out", out_d, '0);
        chk("R10 D oe", oe_d, '0);
    endtask

    task automatic wr(input int a, input logic [L-1:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        case (a)
            0: e_out_b = d;
            1: begin e_out_a = e_out_a | swp(d); e_out_c = d; end
            2: e_out_a = e_out_a & ~swp(d);
            3: begin e_dir_a = swp(d); e_dir_c = d; e_dir_d = d; end
            default: ;
        endcase
        check_lines();
    endtask

    task automatic rd(input int a);
        logic [L-1:0] xa, xb, xc, xd;
        @(negedge clk);
        addr = AW'(a); re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        case (a)
            0: begin xa = swp(pads); xb = pads; xc = pads; xd = pads; end
            3: begin xa = swp(e_dir_a); xb = '0; xc = e_dir_c; xd = e_dir_d; end
            default: begin xa = '0; xb = '0; xc = '0; xd = '0; end
        endcase
        chk("R2 R7 R11 R12 A rdata", rd_a, xa);
        chk("R2 R12 B rdata", rd_b, xb);
        chk("R2 R8 R12 C rdata", rd_c, xc);
        chk("R2 R12 D rdata", rd_d, xd);
        @(negedge clk);
        chk("R13 A rdata idle", rd_a, '0);
        chk("R13 C rdata idle", rd_c, '0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        e_out_a = '0; e_out_b = '0; e_out_c = '0;
        e_dir_a = '0; e_dir_c = '1; e_dir_d = '0;
        repeat (3) @(negedge clk);
        chk("R1 A out reset", out_a, '0);
        chk("R1 A oe reset", oe_a, '0);
        chk("R1 C oe reset", oe_c, '0);
        chk("R1 A rdata reset", rd_a, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_lines();

        // sweep every line through set, level, clear, direction and hole writes
        for (int i = 0; i < 16; i++) begin
            wr(1, 16'h1 << i);
            wr(0, 16'(i * 16'h1111) ^ 16'h5A0F);
            wr(1, 16'h1 << ((i + 5) % 16));
            wr(2, 16'h1 << ((i + 3) % 16));
            wr(3, 16'h00FF ^ (16'h1 << i));
            wr(4 + (i % 4), 16'hFFFF);
        end
        wr(2, 16'hFFFF);
        wr(1, 16'h0000);

        // pad patterns through the synchronizer, and every address read
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pads = (16'h1 << i) ^ 16'(i * 16'h0F0F);
            repeat (2) @(negedge clk);
            rd(0);
        end
        for (int a = 0; a < 8; a++) rd(a);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule